// File: doc/BRIEF.md
# Address Translation Unit with Hardware Table Walk

This block converts 16-bit virtual addresses into physical addresses. Each address is split into a page number and an in-page offset. The page number is first looked up in a small fully associative cache of recent translations. A hit answers in the next cycle. On a miss, a hardware walker fetches one 16-bit table word from memory. The table is single-level and is indexed from a base register. The walker then either refills the cache and returns the physical address, or reports a page fault.

A host drives requests through a valid/ready port. The block handles one request at a time. It keeps its request port not-ready while a walk is outstanding. Software sets the table base through a one-cycle write strobe, and this write also discards every cached translation. A separate flush strobe discards the cached translations without changing the base.

Top module: `xlat_unit`

## Requirements
- R1: The low 13 bits of the virtual address (offset) appear unchanged as the low 13 bits of a successful physical address. The upper 3 bits are the page number, and the physical address is {frame[7:0], offset}.
- R2: A request accepted (req_valid and req_ready high at a clock edge) whose page number matches a valid cached entry produces rsp_valid with rsp_fault low in the very next cycle. No memory read is issued.
- R3: A request that misses raises mem_req_valid in the next cycle at address base + 2*page_number, using the base in force when the request was accepted. The address is held stable until mem_req_ready is seen. req_ready stays low from then until the response cycle.
- R4: A table word has bit 15 as the present flag and bits 7:0 as the frame number. Bit 14 (modified) and all other bits do not affect the result. If the word is present, the response comes in the cycle after mem_rsp_valid, with fault low, and the pair is installed in the cache so the next request to that page hits.
- R5: A fetched word with bit 15 clear gives a response with rsp_fault high and rsp_paddr zero. Nothing is installed, so a repeat request to the same page walks again.
- R6: A refill goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry at a rotating pointer, which then moves to the entry after the victim. Flushing does not move the pointer.
- R7: A pulse on flush or base_we invalidates every entry at that clock edge. A request accepted in the same cycle still sees the old contents. A refill landing in the same cycle is discarded.
- R8: Synchronous reset invalidates all entries, zeroes the base register and the rotating pointer, idles the walker (req_ready high, mem_req_valid and rsp_valid low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 21 | Physical address (zero on fault) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 16 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 16 | Table word |
| base_we | input | 1 | Write strobe for the table base |
| base_wdata | input | 16 | New table base |
| flush | input | 1 | Invalidate all cached translations |

## Verification
The hardest cases to reach from the ports are the collisions of an invalidation with other activity in the same cycle. One is a flush arriving with the refill word. The other is a flush arriving with a lookup that would hit. The stimulus reaches them by holding a test page's memory reply until a chosen cycle, then raising flush on exactly that edge. Round-robin eviction needs a full cache, so the bench first fills every entry with distinct pages. It then revisits evicted pages to see which ones walk again.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FETCH = 2'd1,
    WK_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 4,
  parameter int KEY_W   = 3,
  parameter int VAL_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [KEY_W-1:0]   look_key,
  output logic               look_hit,
  output logic [VAL_W-1:0]   look_val,
  input  logic               clear,
  input  logic               ins_en,
  input  logic [KEY_W-1:0]   ins_key,
  input  logic [VAL_W-1:0]   ins_val,
  output logic [ENTRIES-1:0] vld_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [VAL_W-1:0]   val_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   free_idx;
  logic               any_free;
  logic [IDX_W-1:0]   victim;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (key_q[g] == look_key);
    end
  endgenerate

  always_comb begin
    look_val = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) look_val = look_val | val_q[i];
    end
  end
  assign look_hit = |match;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
  assign victim = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (clear) begin
      vld_q <= '0;
    end else if (ins_en) begin
      vld_q[victim] <= 1'b1;
      if (!any_free) begin
        rr_q <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && !clear) begin
      key_q[victim] <= ins_key;
      val_q[victim] <= ins_val;
    end
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
  import xlat_pkg::*;
#(
  parameter int VA_W     = 16,
  parameter int PN_W     = 3,
  parameter int FRAME_W  = 8,
  parameter int PTE_W    = 16,
  parameter int MA_W     = 16,
  parameter int PRES_BIT = 15,
  localparam int OFF_W   = VA_W - PN_W,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               hit,
  input  logic [FRAME_W-1:0] hit_frame,
  input  logic [MA_W-1:0]    base,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               ins_en,
  output logic [PN_W-1:0]    ins_key,
  output logic [FRAME_W-1:0] ins_val
);
  walk_state_e         st_q;
  logic [PN_W-1:0]     pn_q;
  logic [OFF_W-1:0]    off_q;
  logic                fire;
  logic                present;
  logic [PN_W-1:0]     req_pn;
  logic [OFF_W-1:0]    req_off;

  assign req_pn  = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];
  assign req_ready     = (st_q == WK_IDLE);
  assign mem_req_valid = (st_q == WK_FETCH);
  assign fire    = req_valid && req_ready;
  assign present = mem_rsp_data[PRES_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= WK_IDLE;
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_paddr    <= '0;
      mem_req_addr <= '0;
      pn_q         <= '0;
      off_q        <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      unique case (st_q)
        WK_IDLE: begin
          if (fire) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_paddr <= {hit_frame, req_off};
            end else begin
              pn_q         <= req_pn;
              off_q        <= req_off;
              mem_req_addr <= base + MA_W'({req_pn, 1'b0});
              st_q         <= WK_FETCH;
            end
          end
        end
        WK_FETCH: begin
          if (mem_req_ready) st_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            st_q      <= WK_IDLE;
            if (present) begin
              rsp_paddr <= {mem_rsp_data[FRAME_W-1:0], off_q};
            end else begin
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
            end
          end
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign ins_en  = (st_q == WK_WAIT) && mem_rsp_valid && present;
  assign ins_key = pn_q;
  assign ins_val = mem_rsp_data[FRAME_W-1:0];
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int VA_W     = 16,
  parameter int PN_W     = 3,
  parameter int FRAME_W  = 8,
  parameter int ENTRIES  = 4,
  parameter int PTE_W    = 16,
  parameter int MA_W     = 16,
  parameter int PRES_BIT = 15,
  localparam int OFF_W   = VA_W - PN_W,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  input  logic              base_we,
  input  logic [MA_W-1:0]   base_wdata,
  input  logic              flush
);
  logic [MA_W-1:0]    base_q;
  logic               wipe;
  logic               hit;
  logic [FRAME_W-1:0] hit_frame;
  logic               ins_en;
  logic [PN_W-1:0]    ins_key;
  logic [FRAME_W-1:0] ins_val;
  logic [ENTRIES-1:0] ent_vld;

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  assign wipe = flush || base_we;

  xlat_cam #(
    .ENTRIES (ENTRIES),
    .KEY_W   (PN_W),
    .VAL_W   (FRAME_W)
  ) cam_i (
    .clk      (clk),
    .rst      (rst),
    .look_key (req_vaddr[VA_W-1:OFF_W]),
    .look_hit (hit),
    .look_val (hit_frame),
    .clear    (wipe),
    .ins_en   (ins_en),
    .ins_key  (ins_key),
    .ins_val  (ins_val),
    .vld_o    (ent_vld)
  );

  xlat_walk #(
    .VA_W     (VA_W),
    .PN_W     (PN_W),
    .FRAME_W  (FRAME_W),
    .PTE_W    (PTE_W),
    .MA_W     (MA_W),
    .PRES_BIT (PRES_BIT)
  ) walk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .hit           (hit),
    .hit_frame     (hit_frame),
    .base          (base_q),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .ins_en        (ins_en),
    .ins_key       (ins_key),
    .ins_val       (ins_val)
  );
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
  parameter int VA_W    = 16,
  parameter int PN_W    = 3,
  parameter int FRAME_W = 8,
  parameter int ENTRIES = 4,
  parameter int MA_W    = 16,
  localparam int OFF_W  = VA_W - PN_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [MA_W-1:0]    mem_req_addr,
  input logic               flush,
  input logic               base_we,
  input logic [ENTRIES-1:0] ent_vld
);
  logic [OFF_W-1:0] off_hold;

  always_ff @(posedge clk) begin
    if (rst) off_hold <= '0;
    else if (req_valid && req_ready) off_hold <= req_vaddr[OFF_W-1:0];
  end

  p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_hold));

  p_hit_or_walk_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid || mem_req_valid));

  p_single_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_fault_no_pa_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0));

  p_wipe_all_r7: assert property (@(posedge clk) disable iff (rst)
    (flush || base_we) |=> (ent_vld == '0));

  p_reset_idle_r8: assert property (@(posedge clk)
    rst |=> (ent_vld == '0 && !rsp_valid && !mem_req_valid && req_ready));
endmodule

bind xlat_unit xlat_unit_chk #(
  .VA_W    (VA_W),
  .PN_W    (PN_W),
  .FRAME_W (FRAME_W),
  .ENTRIES (ENTRIES),
  .MA_W    (MA_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_paddr     (rsp_paddr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .flush         (flush),
  .base_we       (base_we),
  .ent_vld       (ent_vld)
);

// File: tb/xlat_unit_tb_top.sv
`timescale 1ns/1ps
module xlat_unit_tb_top;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [20:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        base_we = 1'b0;
  logic [15:0] base_wdata = '0;
  logic        flush = 1'b0;

  always #2.5 clk = ~clk;

  xlat_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .base_we(base_we), .base_wdata(base_wdata), .flush(flush)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int m_key[NE];
  int m_frm[NE];
  bit m_vld[NE];
  int m_ptr = 0;
  int m_base = 0;
  int pt[int];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input int pn);
    for (int i = 0; i < NE; i++) if (m_vld[i] && m_key[i] == pn) return i;
    return -1;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < NE; i++) m_vld[i] = 0;
  endfunction

  function automatic void m_install(input int pn, input int frm);
    int v = -1;
    for (int i = 0; i < NE; i++) if (!m_vld[i] && v < 0) v = i;
    if (v < 0) begin
      v = m_ptr;
      m_ptr = (v + 1) % NE;
    end
    m_vld[v] = 1; m_key[v] = pn; m_frm[v] = frm;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // starts and ends at a negedge
  task automatic do_req(input int va, input bit clr_acc, input bit clr_rsp,
                        input int lat, input int rdly);
    int pn = (va >> 13) & 7;
    int off = va & 16'h1FFF;
    int idx, addr, data;
    bit pres;
    req_valid = 1; req_vaddr = 16'(va); flush = clr_acc;
    idx = m_find(pn);
    addr = (m_base + pn * 2) & 16'hFFFF;
    tick();
    req_valid = 0; flush = 0;
    if (clr_acc) m_clear();
    if (idx >= 0) begin
      check(rsp_valid && !rsp_fault, "R2 hit response", {rsp_valid, rsp_fault}, 2'b10);
      check(rsp_paddr == 21'((m_frm[idx] << 13) | off), "R1 hit paddr",
            rsp_paddr, (m_frm[idx] << 13) | off);
      check(!mem_req_valid, "R2 no memory read on hit", mem_req_valid, 0);
    end else begin
      check(!rsp_valid && mem_req_valid, "R3 walk starts", {rsp_valid, mem_req_valid}, 2'b01);
      check(mem_req_addr == 16'(addr), "R3 table address", mem_req_addr, addr);
      check(!req_ready, "R3 busy during walk", req_ready, 0);
      for (int k = 0; k < rdly; k++) begin
        tick();
        check(mem_req_valid && mem_req_addr == 16'(addr), "R3 request held",
              mem_req_addr, addr);
      end
      mem_req_ready = 1;
      tick();
      mem_req_ready = 0;
      for (int k = 1; k < lat; k++) begin
        check(!rsp_valid && !req_ready && !mem_req_valid, "R3 waiting",
              {rsp_valid, req_ready, mem_req_valid}, 0);
        tick();
      end
      data = pt.exists(addr) ? pt[addr] : 0;
      pres = data[15];
      mem_rsp_valid = 1; mem_rsp_data = 16'(data); flush = clr_rsp;
      tick();
      mem_rsp_valid = 0; mem_rsp_data = 16'h0; flush = 0;
      if (clr_rsp) m_clear();
      else if (pres) m_install(pn, data & 8'hFF);
      check(rsp_valid && rsp_fault == !pres, pres ? "R4 refill response" : "R5 fault response",
            {rsp_valid, rsp_fault}, {1'b1, !pres});
      if (pres)
        check(rsp_paddr == 21'(((data & 8'hFF) << 13) | off), "R4 walk paddr",
              rsp_paddr, ((data & 8'hFF) << 13) | off);
      else
        check(rsp_paddr == 0, "R5 fault paddr zero", rsp_paddr, 0);
      check(req_ready, "R3 ready after response", req_ready, 1);
    end
  endtask

  task automatic set_base(input int b);
    base_we = 1; base_wdata = 16'(b);
    tick();
    base_we = 0;
    m_base = b; m_clear();
  endtask

  task automatic do_flush();
    flush = 1;
    tick();
    flush = 0;
    m_clear();
  endtask

  task automatic do_reset();
    rst = 1;
    tick(); tick();
    rst = 0;
    m_clear(); m_ptr = 0; m_base = 0;
    check(req_ready && !rsp_valid && !mem_req_valid, "R8 reset state",
          {req_ready, rsp_valid, mem_req_valid}, 3'b100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // table at base 0x1000: frame = 0x10 + 3*pn, page 5 absent, page 6 modified
    for (int p = 0; p < 8; p++) pt[16'h1000 + p * 2] = 16'h8000 | (8'h10 + 3 * p);
    pt[16'h1000 + 10] = 16'h0033;
    pt[16'h1000 + 12] = 16'hC000 | 8'h52;
    set_base(16'h1000);

    do_req(16'h0123, 0, 0, 3, 2);            // R3 miss, R4 refill
    do_req(16'h1FFF, 0, 0, 1, 0);            // R2 hit, R1 max offset
    do_req(16'h2000, 0, 0, 1, 0);            // page 1 miss
    do_req(16'h0000, 0, 0, 1, 0);            // back-to-back hits
    do_req(16'h3ABC, 0, 0, 1, 0);
    do_req(16'h0777, 0, 0, 1, 0);
    do_req(16'hA010, 0, 0, 2, 1);            // R5 fault
    do_req(16'hA010, 0, 0, 1, 0);            // R5 walks again
    do_req(16'hC456, 0, 0, 4, 3);            // R4 modified bit ignored
    do_req(16'h4001, 0, 0, 1, 0);            // page 2 fills last free slot
    do_req(16'h6001, 0, 0, 1, 0);            // R6 evicts entry at pointer
    do_req(16'h0002, 0, 0, 1, 0);            // R6 page 0 evicted -> walk
    do_req(16'hC003, 0, 0, 1, 0);            // R6 check survivors
    do_req(16'h2004, 0, 0, 1, 0);
    do_req(16'h4005, 0, 0, 1, 0);

    do_flush();                               // R7 flush
    do_req(16'h4006, 0, 0, 1, 0);            // now a walk
    do_req(16'h4007, 1, 0, 1, 0);            // R7 lookup sees old contents
    do_req(16'h4008, 0, 0, 1, 0);            // R7 then misses
    do_req(16'hE009, 0, 1, 2, 0);            // R7 refill dropped by flush
    do_req(16'hE00A, 0, 0, 1, 0);            // walks again

    for (int p = 0; p < 8; p++) pt[16'h2000 + p * 2] = 16'h8000 | (8'hA0 + p);
    pt[16'h2000 + 14] = 16'h7FFF;
    do_req(16'h4010, 0, 0, 1, 0);            // cached before base write
    set_base(16'h2000);                       // R7 base write clears
    do_req(16'h4011, 0, 0, 2, 1);            // new table address 0x2004

    for (int n = 0; n < 300; n++) begin
      int r = $urandom % 40;
      if (r == 0) do_flush();
      else if (r == 1) set_base(($urandom % 2) ? 16'h1000 : 16'h2000);
      else do_req(16'($urandom), 0, 0, 1 + ($urandom % 4), $urandom % 3);
    end

    do_req(16'h2222, 0, 0, 1, 0);
    do_reset();                               // R8 clears cache and base
    pt[2] = 16'h8000 | 8'h77;
    do_req(16'h2222, 0, 0, 1, 0);            // miss at base 0 + 2
    do_req(16'h2223, 0, 0, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule